// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit linear address into a 32-bit physical address. It looks the address up in a two-level page table held in memory. A translation request is accepted only while the walker is idle. The walker then makes two dependent reads over a memory read port that allows one read at a time.

The first read fetches a directory entry. Its address is the directory base plus the top ten linear-address bits times four. That entry gives the base of a page table. The second read fetches the page-table entry, indexed by the middle ten bits. That entry gives the frame base, and the low twelve bits of the linear address are added to it.

Bit 0 of each entry is a present flag. A clear flag at either level ends the walk early and reports a page fault along with the linear address that caused it. With paging switched off, the walker makes no memory read and returns the linear address unchanged one cycle after the request.

Top module: `ptw_top`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0 and mem_req is 0.
- R2: A request is taken only while req_ready is 1; req_valid raised while a walk is in progress is ignored and produces no extra response.
- R3: The first read targets dir_base + 4 * laddr[31:22], sampled with the request.
- R4: The second read targets {pde[31:12], 12'h000} + 4 * laddr[21:12], where pde is the data returned by the first read.
- R5: When both entries have bit 0 set, resp_paddr = {pte[31:12], 12'h000} + laddr[11:0] and resp_fault = 0, so the low 12 bits match the linear address.
- R6: A directory entry with bit 0 clear gives resp_fault = 1 and resp_laddr equal to the request address, with no second read.
- R7: A page-table entry with bit 0 clear gives resp_fault = 1 and resp_laddr equal to the request address, after exactly two reads.
- R8: With paging_en = 0 at the request, resp_valid is 1 in the cycle after acceptance, resp_paddr equals the linear address, and no read is issued.
- R9: resp_valid lasts exactly one cycle, and req_ready is 1 in the cycle that follows.
- R10: mem_rvalid while no read is outstanding has no effect: no response appears and the next walk is unaffected.
- R11: Each read is a single-cycle mem_req pulse, and mem_addr stays unchanged until its mem_rvalid arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paging_en | input | 1 | 1 selects a table walk, 0 selects pass-through; sampled with the request |
| dir_base | input | 32 | Directory base register value, sampled with the request |
| req_valid | input | 1 | Translation request |
| req_laddr | input | 32 | Linear address to translate |
| req_ready | output | 1 | Walker idle, request can be accepted |
| mem_req | output | 1 | One-cycle read command |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_paddr | output | 32 | Physical address (zero on fault) |
| resp_fault | output | 1 | Page fault: an entry had bit 0 clear |
| resp_laddr | output | 32 | Linear address of this result, the faulting address on fault |

## Verification
If the walker is stuck in the wrong state or mis-sequenced, the ports show it within one walk. A skipped level shows as the wrong number of reads. A fault taken at the wrong point shows as a missing or extra second read. A state that does not leave the result step shows as a response strobe longer than one cycle, or as a ready that does not come back in the next cycle. A corrupted captured base or address shows at the very next read, as a wrong mem_addr, or in the physical address of that same result.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_READ_DIR = 2'd1,
        ST_READ_PTE = 2'd2,
        ST_DONE     = 2'd3
    } walk_state_t;

endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int ENT_SH = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAD_W = ADDR_W - IDX_W - ENT_SH;

    logic [ADDR_W-1:0] scaled;

    always_comb begin
        scaled = {{PAD_W{1'b0}}, index, {ENT_SH{1'b0}}};
        addr   = base + scaled;
    end
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-1:0] entry,
    output logic              present,
    output logic [ADDR_W-1:0] frame_base
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << OFF_W) - 64'd1);

    always_comb begin
        present    = entry[0];
        frame_base = entry & ~LOW_MASK;
    end
endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              paging_en,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_laddr,
    output logic              req_ready,
    output logic              mem_req,
    output logic              sel_pte,
    input  logic              mem_rvalid,
    input  logic              ent_present,
    input  logic [ADDR_W-1:0] ent_base,
    output logic [ADDR_W-1:0] laddr_q_o,
    output logic [ADDR_W-1:0] dbase_q_o,
    output logic [ADDR_W-1:0] tbase_q_o,
    output logic              resp_valid,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic              resp_fault,
    output logic [ADDR_W-1:0] resp_laddr
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << OFF_W) - 64'd1);

    typedef struct packed {
        walk_state_t       st;
        logic              issued;
        logic [ADDR_W-1:0] laddr;
        logic [ADDR_W-1:0] dbase;
        logic [ADDR_W-1:0] tbase;
        logic [ADDR_W-1:0] paddr;
        logic              fault;
    } walk_regs_t;

    walk_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.laddr  = req_laddr;
                    r_d.dbase  = dir_base;
                    r_d.fault  = 1'b0;
                    r_d.issued = 1'b0;
                    if (paging_en) begin
                        r_d.st = ST_READ_DIR;
                    end else begin
                        r_d.paddr = req_laddr;
                        r_d.st    = ST_DONE;
                    end
                end
            end
            ST_READ_DIR: begin
                if (!r_q.issued) begin
                    r_d.issued = 1'b1;
                end else if (mem_rvalid) begin
                    r_d.issued = 1'b0;
                    if (ent_present) begin
                        r_d.tbase = ent_base;
                        r_d.st    = ST_READ_PTE;
                    end else begin
                        r_d.fault = 1'b1;
                        r_d.paddr = '0;
                        r_d.st    = ST_DONE;
                    end
                end
            end
            ST_READ_PTE: begin
                if (!r_q.issued) begin
                    r_d.issued = 1'b1;
                end else if (mem_rvalid) begin
                    r_d.issued = 1'b0;
                    if (ent_present) begin
                        r_d.paddr = ent_base + (r_q.laddr & LOW_MASK);
                    end else begin
                        r_d.fault = 1'b1;
                        r_d.paddr = '0;
                    end
                    r_d.st = ST_DONE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, issued: 1'b0, laddr: '0, dbase: '0,
                     tbase: '0, paddr: '0, fault: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_ready  = (r_q.st == ST_IDLE);
        mem_req    = ((r_q.st == ST_READ_DIR) || (r_q.st == ST_READ_PTE)) && !r_q.issued;
        sel_pte    = (r_q.st == ST_READ_PTE);
        resp_valid = (r_q.st == ST_DONE);
        resp_paddr = r_q.paddr;
        resp_fault = r_q.fault;
        resp_laddr = r_q.laddr;
        laddr_q_o  = r_q.laddr;
        dbase_q_o  = r_q.dbase;
        tbase_q_o  = r_q.tbase;
    end

    // R2: a taken request closes the request window at once
    assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8: pass-through returns the request address in the next cycle
    assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !paging_en) |=>
            (resp_valid && !resp_fault && resp_paddr == $past(req_laddr)));

    // R9: single-cycle result, then ready again
    assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));

    // R5: page offset survives translation
    assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (resp_paddr[OFF_W-1:0] == resp_laddr[OFF_W-1:0]));

    // R6: a fault carries no physical address
    assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_paddr == '0));

    // R11: read command is a one-cycle pulse
    assert_single_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R10: no read issued while idle
    assert_no_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);
endmodule

// File: rtl/ptw_top.sv
module ptw_top #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int OFF_W  = 12,
    parameter int ENT_SH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              paging_en,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_laddr,
    output logic              req_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              resp_valid,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic              resp_fault,
    output logic [ADDR_W-1:0] resp_laddr
);
    localparam int LEVELS = 2;

    initial begin
        if (2 * IDX_W + OFF_W != ADDR_W) begin
            $display("ptw_top: index and offset widths do not fill the address");
        end
    end

    logic              sel_pte;
    logic              ent_present;
    logic [ADDR_W-1:0] ent_base;
    logic [ADDR_W-1:0] laddr_q, dbase_q, tbase_q;
    logic [ADDR_W-1:0] lvl_base [LEVELS];
    logic [IDX_W-1:0]  lvl_idx  [LEVELS];
    logic [ADDR_W-1:0] lvl_addr [LEVELS];

    always_comb begin
        lvl_base[0] = dbase_q;
        lvl_base[1] = tbase_q;
        lvl_idx[0]  = laddr_q[ADDR_W-1 -: IDX_W];
        lvl_idx[1]  = laddr_q[OFF_W +: IDX_W];
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        ptw_entry_addr #(
            .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ENT_SH(ENT_SH)
        ) u_ea (
            .base (lvl_base[g]),
            .index(lvl_idx[g]),
            .addr (lvl_addr[g])
        );
    end

    always_comb begin
        mem_addr = sel_pte ? lvl_addr[1] : lvl_addr[0];
    end

    ptw_entry_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
        .entry     (mem_rdata),
        .present   (ent_present),
        .frame_base(ent_base)
    );

    ptw_walk_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .paging_en  (paging_en),
        .dir_base   (dir_base),
        .req_valid  (req_valid),
        .req_laddr  (req_laddr),
        .req_ready  (req_ready),
        .mem_req    (mem_req),
        .sel_pte    (sel_pte),
        .mem_rvalid (mem_rvalid),
        .ent_present(ent_present),
        .ent_base   (ent_base),
        .laddr_q_o  (laddr_q),
        .dbase_q_o  (dbase_q),
        .tbase_q_o  (tbase_q),
        .resp_valid (resp_valid),
        .resp_paddr (resp_paddr),
        .resp_fault (resp_fault),
        .resp_laddr (resp_laddr)
    );

    // R11: the read address holds while its read is outstanding
    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> (mem_addr == $past(mem_addr)));
endmodule

// File: tb/sim_ptw_top.sv
`timescale 1ns/100ps
module sim_ptw_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        paging_en = 1'b1;
    logic [31:0] dir_base = 32'h0;
    logic        req_valid = 1'b0;
    logic [31:0] req_laddr = 32'h0;
    logic        req_ready, mem_req, resp_valid, resp_fault;
    logic [31:0] mem_addr, resp_paddr, resp_laddr;
    logic        rv = 1'b0, spur = 1'b0;
    logic [31:0] rdata = 32'h0;
    logic        mem_rvalid;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign mem_rvalid = rv | spur;

    ptw_top u0 (
        .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .dir_base(dir_base),
        .req_valid(req_valid), .req_laddr(req_laddr), .req_ready(req_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(rdata), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_fault(resp_fault), .resp_laddr(resp_laddr)
    );

    // memory model
    logic [31:0] bmem [logic [31:0]];
    int          lat = 1;
    int          cnt = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_log [8];
    logic [31:0] lat_addr = 32'h0;
    logic        addr_moved = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 0;
            rv  <= 1'b0;
        end else begin
            rv <= 1'b0;
            if (mem_req) begin
                rd_log[rd_cnt % 8] <= mem_addr;
                rd_cnt   <= rd_cnt + 1;
                cnt      <= lat;
                lat_addr <= mem_addr;
            end else if (cnt > 0) begin
                cnt <= cnt - 1;
                if (mem_addr != lat_addr) addr_moved <= 1'b1;
                if (cnt == 1) begin
                    rv    <= 1'b1;
                    rdata <= bmem.exists(lat_addr) ? bmem[lat_addr] : 32'h0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    logic [31:0] o_paddr, o_laddr;
    logic        o_fault;
    int          o_reads, o_cycles, o_base;
    bit          o_pulse_ok;

    task automatic walk(input logic [31:0] la, input logic pg);
        @(negedge clk);
        req_valid = 1'b1;
        req_laddr = la;
        paging_en = pg;
        o_base = rd_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        o_cycles = 1;
        while (!resp_valid && o_cycles < 200) begin
            @(negedge clk);
            o_cycles++;
        end
        o_paddr = resp_paddr;
        o_fault = resp_fault;
        o_laddr = resp_laddr;
        o_reads = rd_cnt - o_base;
        if (!resp_valid) chk(0, "timeout waiting for resp_valid", 0, 1);
        @(negedge clk);
        o_pulse_ok = !resp_valid && req_ready;
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
        chk(resp_valid == 1'b0, "R1 resp_valid after reset", resp_valid, 0);
        chk(mem_req == 1'b0, "R1 mem_req after reset", mem_req, 0);
    endtask

    task automatic t_normal;
        dir_base = 32'h0001_0000;
        bmem[32'h0001_0004] = 32'h0002_0001;
        bmem[32'h0002_000C] = 32'h0ABC_D003;
        lat = 1;
        walk(32'h0040_3ABC, 1'b1);
        chk(o_reads == 2, "R3 two reads", o_reads, 2);
        chk(rd_log[o_base % 8] == 32'h0001_0004, "R3 directory address", rd_log[o_base % 8], 32'h0001_0004);
        chk(rd_log[(o_base + 1) % 8] == 32'h0002_000C, "R4 table address", rd_log[(o_base + 1) % 8], 32'h0002_000C);
        chk(o_paddr == 32'h0ABC_DABC, "R5 physical address", o_paddr, 32'h0ABC_DABC);
        chk(o_fault == 1'b0, "R5 no fault", o_fault, 0);
        chk(o_pulse_ok, "R9 single pulse then ready", o_pulse_ok, 1);
    endtask

    task automatic t_high_index;
        dir_base = 32'h0001_0000;
        bmem[32'h0001_0FFC] = 32'h0003_0FF1;
        bmem[32'h0003_0FFC] = 32'h1234_5001;
        lat = 3;
        walk(32'hFFFF_F123, 1'b1);
        chk(rd_log[o_base % 8] == 32'h0001_0FFC, "R3 top index address", rd_log[o_base % 8], 32'h0001_0FFC);
        chk(rd_log[(o_base + 1) % 8] == 32'h0003_0FFC, "R4 flag bits masked from table base", rd_log[(o_base + 1) % 8], 32'h0003_0FFC);
        chk(o_paddr == 32'h1234_5123, "R5 physical address high index", o_paddr, 32'h1234_5123);
    endtask

    task automatic t_unaligned_base;
        dir_base = 32'h0006_0010;
        bmem[32'h0006_0018] = 32'h0007_0001;
        bmem[32'h0007_0000] = 32'h0008_8001;
        lat = 2;
        walk(32'h0080_0FFF, 1'b1);
        chk(rd_log[o_base % 8] == 32'h0006_0018, "R3 base plus scaled index", rd_log[o_base % 8], 32'h0006_0018);
        chk(o_paddr == 32'h0008_8FFF, "R5 physical address index zero", o_paddr, 32'h0008_8FFF);
    endtask

    task automatic t_dir_fault;
        dir_base = 32'h0001_0000;
        bmem[32'h0001_0008] = 32'h0004_0000;
        lat = 2;
        walk(32'h0080_0000, 1'b1);
        chk(o_fault == 1'b1, "R6 fault flag", o_fault, 1);
        chk(o_laddr == 32'h0080_0000, "R6 faulting address", o_laddr, 32'h0080_0000);
        chk(o_reads == 1, "R6 single read", o_reads, 1);
        chk(o_pulse_ok, "R9 pulse after fault", o_pulse_ok, 1);
    endtask

    task automatic t_pte_fault;
        dir_base = 32'h0001_0000;
        bmem[32'h0001_000C] = 32'h0005_0001;
        bmem[32'h0005_0014] = 32'h0009_9000;
        lat = 1;
        walk(32'h00C0_5444, 1'b1);
        chk(o_fault == 1'b1, "R7 fault flag", o_fault, 1);
        chk(o_laddr == 32'h00C0_5444, "R7 faulting address", o_laddr, 32'h00C0_5444);
        chk(o_reads == 2, "R7 two reads", o_reads, 2);
    endtask

    task automatic t_bypass;
        walk(32'hDEAD_BEEF, 1'b0);
        chk(o_cycles == 1, "R8 result next cycle", o_cycles, 1);
        chk(o_paddr == 32'hDEAD_BEEF, "R8 address unchanged", o_paddr, 32'hDEAD_BEEF);
        chk(o_reads == 0, "R8 no read", o_reads, 0);
        chk(o_fault == 1'b0, "R8 no fault", o_fault, 0);
        paging_en = 1'b1;
    endtask

    task automatic t_busy;
        int extra;
        dir_base = 32'h0001_0000;
        lat = 6;
        @(negedge clk);
        req_valid = 1'b1;
        req_laddr = 32'h0040_3ABC;
        paging_en = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b0, "R2 busy after accept", req_ready, 0);
        req_laddr = 32'hFFFF_F123;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid) @(negedge clk);
        chk(resp_paddr == 32'h0ABC_DABC, "R2 first request result kept", resp_paddr, 32'h0ABC_DABC);
        extra = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (resp_valid) extra++;
        end
        chk(extra == 0, "R2 no response for ignored request", extra, 0);
    endtask

    task automatic t_spurious;
        int seen;
        @(negedge clk);
        spur = 1'b1;
        @(negedge clk);
        spur = 1'b0;
        seen = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (resp_valid || mem_req || !req_ready) seen++;
        end
        chk(seen == 0, "R10 stray rvalid ignored", seen, 0);
        lat = 2;
        walk(32'h0040_3ABC, 1'b1);
        chk(o_paddr == 32'h0ABC_DABC && o_reads == 2, "R10 next walk unaffected", o_paddr, 32'h0ABC_DABC);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_high_index();
        t_unaligned_base();
        t_dir_fault();
        t_pte_fault();
        t_bypass();
        t_busy();
        t_spurious();
        chk(addr_moved == 1'b0, "R11 address held during read", addr_moved, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule